// File: doc/BRIEF.md
# Transmit Message Byte Sequencer

This block hands a message to a bit-level line transmitter one byte at a time. Software loads a header byte and sets a start control bit. The sequencer then raises `txGo` and offers the byte on `txByte`. The bit transmitter reports each bit it finishes with a pulse and the index of that bit. When the byte is half sent, the sequencer asks for the following byte. It checks the acknowledge slot, moves to the next byte, and closes the message with a status flag.

The header's upper nibble is the sender's own address and passes through unchanged; its lower nibble is the destination. Destination 0xF marks a broadcast, for which acknowledge polarity is inverted. If software sets the end bit before it sets the start bit, the message is the header alone (a ping). Losing arbitration does not consume the request: the start bit stays set and the header is sent again. Underrun, a line error, a missing acknowledge, normal completion and dropping `enable` all end the message and clear both control bits.

Top module: `tx_msg_seq`

## Requirements
- R1: After reset, `flags`, `txGo`, `startBit` and `endBit` are all 0.
- R2: With a header byte written and the start bit set, `txGo` rises within a few cycles and `txByte` equals the written header. Its bits 7:4 are the sender address as written. `txLast` equals the end bit at that moment.
- R3: Flag bit 0 (byte request) is set when a bit report with index 3 arrives (bit indices run 0..7 for data MSB first, 8 for the end-of-message bit, 9 for acknowledge). This happens only when the current byte is not the last.
- R4: On a positive acknowledge of a non-last byte, the written next byte appears on `txByte`. `txLast` is 1 exactly when the end bit was set before that load.
- R5: On a positive acknowledge of the last byte, flag bit 1 (end) is set, `startBit` and `endBit` clear, and `txGo` falls.
- R6: After a byte request, 6 `periodTick` pulses with no data write set flag bit 2 (underrun) and abort. Five pulses do not, and a write inside the window cancels the deadline.
- R7: A `lineErr` pulse during transmission sets flag bit 3 and aborts with both control bits cleared.
- R8: For a directed destination, `ackSeen`=0 in the acknowledge slot sets flag bit 4 (missing acknowledge) and aborts. For broadcast destination 0xF, `ackSeen`=1 does the same, and `ackSeen`=0 is positive.
- R9: `arbLost` during the header drops `txGo` but keeps `startBit`, and the same header is relaunched without a new write.
- R10: End bit set before start bit sends only the header with `txLast`=1. No byte request is raised, and the end flag follows its acknowledge.
- R11: `enable`=0 clears `startBit` and `endBit` and drops `txGo`; start and end writes are ignored while `enable` is 0.
- R12: A 1 in bit k of `flagClr` clears flag k only; other flags keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Block enable; low aborts and clears control bits |
| startWr | input | 1 | Pulse: set start control bit |
| endWr | input | 1 | Pulse: set end control bit |
| dataWr | input | 1 | Pulse: write `dataIn` to the data holding register |
| dataIn | input | 8 | Byte to transmit |
| flagClr | input | 5 | Write-1-to-clear pulse per flag |
| bitDone | input | 1 | Bit transmitter finished one bit |
| bitIdx | input | 4 | Index of the bit just finished (0..9) |
| ackSeen | input | 1 | Line driven low in the acknowledge slot |
| arbLost | input | 1 | Arbitration lost pulse |
| lineErr | input | 1 | Line seen low while released |
| periodTick | input | 1 | One pulse per nominal data-bit period |
| txGo | output | 1 | Transmission of the current byte in progress |
| txByte | output | 8 | Byte being sent |
| txLast | output | 1 | Current byte is the last of the message |
| startBit | output | 1 | Start control bit |
| endBit | output | 1 | End control bit |
| flags | output | 5 | Status flags: 0 request, 1 end, 2 underrun, 3 error, 4 missing ack |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a request at bit index 3, the acknowledge at index 9, and a 6-period underrun deadline. With these values the 5-versus-6 tick boundary of the deadline can be reached in a few dozen cycles. Random messages of one to four bytes alternate between directed and broadcast headers, so both acknowledge polarities are covered, along with load and last-byte marking at every position.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
  localparam int FLAG_N  = 5;
  localparam int FLG_REQ = 0;
  localparam int FLG_END = 1;
  localparam int FLG_UDR = 2;
  localparam int FLG_ERR = 3;
  localparam int FLG_ACK = 4;

  typedef struct packed {
    logic takeData;
    logic takeHdr;
    logic setLast;
    logic lastIn;
    logic dropData;
    logic setReq;
    logic setEnd;
    logic setUdr;
    logic setErr;
    logic setAck;
  } seqStrobe_t;
endpackage

// File: rtl/tx_seq_ctrl.sv
module tx_seq_ctrl
  import tx_seq_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int REQ_IDX     = 3,
  parameter int ACK_IDX     = 9,
  parameter int UDR_PERIODS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             startWr,
  input  logic             endWr,
  input  logic             bitDone,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic             ackSeen,
  input  logic             arbLost,
  input  logic             lineErr,
  input  logic             periodTick,
  input  logic             dataValid,
  input  logic             curLast,
  input  logic             isBcast,
  output seqStrobe_t       stb,
  output logic             active,
  output logic             startBit,
  output logic             endBit
);
  localparam int CNT_W = $clog2(UDR_PERIODS + 1);

  logic             retry, firstByte, udrArm;
  logic [CNT_W-1:0] udrCnt;
  logic launch, running, errEv, arbEv, ackEv, ackGood, ackMiss;
  logic finish, nextLoad, udrAtAck, udrTick, underrun, reqEv, abortEv;

  always_comb begin
    launch   = !active && enable && startBit && (retry || dataValid);
    running  = active && enable;
    errEv    = running && lineErr;
    arbEv    = running && !errEv && arbLost && firstByte;
    ackEv    = running && !errEv && !arbEv && bitDone && (bitIdx == IDX_W'(ACK_IDX));
    ackGood  = isBcast ? !ackSeen : ackSeen;
    ackMiss  = ackEv && !ackGood;
    finish   = ackEv && ackGood && curLast;
    nextLoad = ackEv && ackGood && !curLast && dataValid;
    udrAtAck = ackEv && ackGood && !curLast && !dataValid;
    udrTick  = running && !errEv && !arbEv && !ackEv && udrArm && !dataValid &&
               periodTick && (udrCnt == CNT_W'(UDR_PERIODS - 1));
    underrun = udrAtAck || udrTick;
    reqEv    = running && !errEv && !arbEv && bitDone &&
               (bitIdx == IDX_W'(REQ_IDX)) && !curLast;
    abortEv  = errEv || ackMiss || finish || underrun;

    stb          = '0;
    stb.takeData = (launch && !retry) || nextLoad;
    stb.takeHdr  = launch && !retry;
    stb.setLast  = launch || nextLoad;
    stb.lastIn   = endBit;
    stb.dropData = abortEv || !enable;
    stb.setReq   = reqEv;
    stb.setEnd   = finish;
    stb.setUdr   = underrun;
    stb.setErr   = errEv;
    stb.setAck   = ackMiss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; startBit <= 1'b0; endBit <= 1'b0; retry <= 1'b0;
      firstByte <= 1'b0; udrArm <= 1'b0; udrCnt <= '0;
    end else if (!enable) begin
      active <= 1'b0; startBit <= 1'b0; endBit <= 1'b0; retry <= 1'b0;
      firstByte <= 1'b0; udrArm <= 1'b0; udrCnt <= '0;
    end else begin
      if (startWr) startBit <= 1'b1;
      if (endWr)   endBit   <= 1'b1;
      if (launch) begin
        active <= 1'b1; firstByte <= 1'b1; retry <= 1'b0;
        udrArm <= 1'b0; udrCnt <= '0;
      end
      if (arbEv) begin
        active <= 1'b0; retry <= 1'b1; udrArm <= 1'b0;
      end
      if (nextLoad) begin
        firstByte <= 1'b0; udrArm <= 1'b0; udrCnt <= '0;
      end
      if (reqEv) begin
        udrArm <= 1'b1; udrCnt <= '0;
      end else if (udrArm && dataValid) begin
        udrArm <= 1'b0;
      end else if (udrArm && periodTick) begin
        udrCnt <= udrCnt + 1'b1;
      end
      if (abortEv) begin
        active <= 1'b0; startBit <= 1'b0; endBit <= 1'b0;
        retry <= 1'b0; udrArm <= 1'b0; udrCnt <= '0;
      end
    end
  end

  AST_ACTIVE_HAS_START: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> startBit); // R2
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (!startBit && !endBit && !active)); // R5
  AST_UDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    udrCnt < CNT_W'(UDR_PERIODS)); // R6
  AST_ARB_KEEPS_START: assert property (@(posedge clk) disable iff (!rst_n)
    arbEv |=> (startBit && !active)); // R9
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!startBit && !endBit && !active)); // R11
endmodule

// File: rtl/tx_seq_dp.sv
module tx_seq_dp
  import tx_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [FLAG_N-1:0] flagClr,
  input  seqStrobe_t        stb,
  output logic              dataValid,
  output logic              curLast,
  output logic              isBcast,
  output logic [DATA_W-1:0] curByte,
  output logic [FLAG_N-1:0] flags
);
  logic [DATA_W-1:0] dataReg;
  logic [ADDR_W-1:0] destAddr;
  logic [FLAG_N-1:0] flagSet;

  assign flagSet = {stb.setAck, stb.setErr, stb.setUdr, stb.setEnd, stb.setReq};
  assign isBcast = (destAddr == BCAST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataReg <= '0; dataValid <= 1'b0; curByte <= '0; curLast <= 1'b0;
      destAddr <= '0; flags <= '0;
    end else begin
      if (stb.takeData) begin
        curByte   <= dataReg;
        dataValid <= 1'b0;
      end
      if (stb.takeHdr)  destAddr <= dataReg[ADDR_W-1:0];
      if (stb.setLast)  curLast  <= stb.lastIn;
      if (stb.dropData) dataValid <= 1'b0;
      if (dataWr) begin
        dataReg   <= dataIn;
        dataValid <= 1'b1;
      end
      flags <= (flags & ~flagClr) | flagSet;
    end
  end

  AST_LOAD_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    stb.takeData |-> dataValid); // R4
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.setEnd |=> flags[FLG_END]); // R12
endmodule

// File: rtl/tx_msg_seq.sv
module tx_msg_seq
  import tx_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int IDX_W       = 4,
  parameter int REQ_IDX     = 3,
  parameter int ACK_IDX     = 9,
  parameter int UDR_PERIODS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              startWr,
  input  logic              endWr,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [4:0]        flagClr,
  input  logic              bitDone,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              ackSeen,
  input  logic              arbLost,
  input  logic              lineErr,
  input  logic              periodTick,
  output logic              txGo,
  output logic [DATA_W-1:0] txByte,
  output logic              txLast,
  output logic              startBit,
  output logic              endBit,
  output logic [4:0]        flags
);
  seqStrobe_t stb;
  logic dataValid, curLast, isBcast;

  tx_seq_ctrl #(.IDX_W(IDX_W), .REQ_IDX(REQ_IDX), .ACK_IDX(ACK_IDX),
                .UDR_PERIODS(UDR_PERIODS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .startWr(startWr), .endWr(endWr),
    .bitDone(bitDone), .bitIdx(bitIdx), .ackSeen(ackSeen), .arbLost(arbLost),
    .lineErr(lineErr), .periodTick(periodTick), .dataValid(dataValid),
    .curLast(curLast), .isBcast(isBcast), .stb(stb), .active(txGo),
    .startBit(startBit), .endBit(endBit));

  tx_seq_dp #(.DATA_W(DATA_W), .ADDR_W(4)) u_dp (
    .clk(clk), .rst_n(rst_n), .dataWr(dataWr), .dataIn(dataIn), .flagClr(flagClr),
    .stb(stb), .dataValid(dataValid), .curLast(curLast), .isBcast(isBcast),
    .curByte(txByte), .flags(flags));

  assign txLast = curLast;
endmodule

// File: tb/sim_tx_msg_seq.sv
module sim_tx_msg_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, startWr = 1'b0, endWr = 1'b0, dataWr = 1'b0;
  logic [7:0] dataIn = '0;
  logic [4:0] flagClr = '0;
  logic bitDone = 1'b0, ackSeen = 1'b0, arbLost = 1'b0, lineErr = 1'b0, periodTick = 1'b0;
  logic [3:0] bitIdx = '0;
  logic txGo, txLast, startBit, endBit;
  logic [7:0] txByte;
  logic [4:0] flags;
  int nChk = 0, nFail = 0;

  always #4 clk = ~clk;

  tx_msg_seq u0 (.*);

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit bcastOf(logic [7:0] hdr);
    return hdr[3:0] == 4'hF;
  endfunction
  function automatic bit goodAck(logic [7:0] hdr);
    return bcastOf(hdr) ? 1'b0 : 1'b1;
  endfunction

  task automatic pStart(); startWr = 1; @(negedge clk); startWr = 0; endtask
  task automatic pEnd();   endWr = 1;   @(negedge clk); endWr = 0;   endtask
  task automatic pData(logic [7:0] d);
    dataWr = 1; dataIn = d; @(negedge clk); dataWr = 0;
  endtask
  task automatic pClr(logic [4:0] m);
    flagClr = m; @(negedge clk); flagClr = '0;
  endtask
  task automatic pTick(); periodTick = 1; @(negedge clk); periodTick = 0; endtask
  task automatic sendBit(int idx, logic ack);
    bitDone = 1; bitIdx = 4'(idx); ackSeen = ack; periodTick = 1;
    @(negedge clk);
    bitDone = 0; periodTick = 0; ackSeen = 0;
    @(negedge clk);
  endtask
  task automatic waitGo();
    for (int i = 0; i < 6 && !txGo; i++) @(negedge clk);
  endtask

  task automatic runMsg(int n, logic [7:0] hdr);
    logic [7:0] msg [4];
    msg[0] = hdr;
    for (int i = 1; i < 4; i++) msg[i] = 8'($urandom);
    pClr(5'h1F);
    if (n == 1) pEnd();
    pData(hdr);
    pStart();
    waitGo();
    chk("R2 go", txGo, 1);
    chk("R2 header", txByte, hdr);
    chk("R2 src nibble", txByte[7:4], hdr[7:4]);
    chk("R10 last on header", txLast, n == 1);
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < 4; b++) sendBit(b, 0);
      chk("R3 request", flags[0], k < n - 1);
      if (k < n - 1) begin
        if (k == n - 2) pEnd();
        pData(msg[k+1]);
        pClr(5'h01);
      end
      for (int b = 4; b < 9; b++) sendBit(b, 0);
      sendBit(9, goodAck(hdr));
      if (k < n - 1) begin
        chk("R4 next byte", txByte, msg[k+1]);
        chk("R4 last mark", txLast, k + 1 == n - 1);
        chk("R4 still going", txGo, 1);
      end else begin
        chk("R5 end flag", flags[1], 1);
        chk("R5 start clr", startBit, 0);
        chk("R5 end clr", endBit, 0);
        chk("R5 go low", txGo, 0);
        chk("R8 no ack miss", flags[4], 0);
      end
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        nChk++; nFail++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("%0d/%0d checks passed", nChk - nFail, nChk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 flags", flags, 0);
    chk("R1 go", txGo, 0);
    chk("R1 start", startBit, 0);
    chk("R1 end", endBit, 0);
    rst_n = 1; enable = 1;
    @(negedge clk);

    // R10 ping: directed and broadcast
    runMsg(1, 8'h41);
    runMsg(1, 8'h3F);

    // random mixed messages
    for (int m = 0; m < 16; m++) begin
      logic [7:0] h;
      h = 8'($urandom);
      if (m % 2 == 1) h[3:0] = 4'hF; else if (h[3:0] == 4'hF) h[3:0] = 4'h4;
      runMsg(1 + int'($urandom % 4), h);
    end

    // R6 underrun boundary
    pClr(5'h1F);
    pData(8'h12); pStart(); waitGo();
    for (int b = 0; b < 4; b++) sendBit(b, 0);
    chk("R3 req before udr", flags[0], 1);
    repeat (5) pTick();
    chk("R6 five ticks no udr", flags[2], 0);
    chk("R6 five ticks still go", txGo, 1);
    pTick();
    chk("R6 sixth tick udr", flags[2], 1);
    chk("R6 abort go", txGo, 0);
    chk("R6 start clr", startBit, 0);

    // R6 write inside window cancels deadline
    pClr(5'h1F);
    pData(8'h23); pStart(); waitGo();
    for (int b = 0; b < 4; b++) sendBit(b, 0);
    repeat (4) pTick();
    pEnd(); pData(8'h99);
    repeat (10) pTick();
    chk("R6 no udr after write", flags[2], 0);
    for (int b = 4; b < 9; b++) sendBit(b, 0);
    sendBit(9, 1);
    chk("R4 loaded after late write", txByte, 8'h99);
    chk("R4 last", txLast, 1);
    for (int b = 0; b < 9; b++) sendBit(b, 0);
    sendBit(9, 1);
    chk("R5 end after 2 bytes", flags[1], 1);

    // R7 line error
    pClr(5'h1F);
    pData(8'h34); pStart(); waitGo();
    sendBit(0, 0);
    lineErr = 1; @(negedge clk); lineErr = 0;
    chk("R7 err flag", flags[3], 1);
    chk("R7 go low", txGo, 0);
    chk("R7 start clr", startBit, 0);

    // R8 directed nack
    pClr(5'h1F);
    pEnd(); pData(8'h45); pStart(); waitGo();
    for (int b = 0; b < 9; b++) sendBit(b, 0);
    sendBit(9, 0);
    chk("R8 directed miss", flags[4], 1);
    chk("R8 end not set", flags[1], 0);
    chk("R8 start clr", startBit, 0);
    chk("R8 endbit clr", endBit, 0);

    // R8 broadcast negative ack
    pClr(5'h1F);
    pEnd(); pData(8'h5F); pStart(); waitGo();
    for (int b = 0; b < 9; b++) sendBit(b, 0);
    sendBit(9, 1);
    chk("R8 bcast miss", flags[4], 1);
    chk("R8 bcast go low", txGo, 0);

    // R9 arbitration loss retries header
    pClr(5'h1F);
    pEnd(); pData(8'h67); pStart(); waitGo();
    sendBit(0, 0); sendBit(1, 0);
    arbLost = 1; @(negedge clk); arbLost = 0;
    chk("R9 go dropped", txGo, 0);
    chk("R9 start kept", startBit, 1);
    @(negedge clk);
    chk("R9 relaunch", txGo, 1);
    chk("R9 same header", txByte, 8'h67);
    for (int b = 0; b < 9; b++) sendBit(b, 0);
    sendBit(9, 1);
    chk("R9 end after retry", flags[1], 1);

    // R11 enable drop mid message, writes ignored while low
    pClr(5'h1F);
    pData(8'h78); pStart(); waitGo();
    pEnd();
    sendBit(0, 0);
    enable = 0; @(negedge clk);
    chk("R11 go low", txGo, 0);
    chk("R11 start clr", startBit, 0);
    chk("R11 end clr", endBit, 0);
    pStart(); pEnd();
    chk("R11 start ignored", startBit, 0);
    chk("R11 end ignored", endBit, 0);
    chk("R11 flags kept", flags, 0);
    enable = 1; @(negedge clk);

    // R12 selective clear
    pClr(5'h1F);
    pEnd(); pData(8'h89); pStart(); waitGo();
    lineErr = 1; @(negedge clk); lineErr = 0;
    pEnd(); pData(8'h8A); pStart(); waitGo();
    for (int b = 0; b < 9; b++) sendBit(b, 0);
    sendBit(9, 1);
    chk("R12 two flags", flags, 5'h0A);
    pClr(5'h08);
    chk("R12 only err cleared", flags, 5'h02);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule